// File: doc/BRIEF.md
# Bitstream Decimation Filter with Aligned Latency

This block turns the one-bit output of a delta-sigma modulator into signed multi-bit words. It runs at a rate lower by a power-of-two factor N. It is a cascaded integrator-comb filter. The number of stages L is one more than the modulator order K. The integrators run at the modulator rate. A decimating sampler feeds the comb (differencing) stages, which run once per output word.

A shift register of D = N − (L + 2) modulator cycles sits in front of the first integrator. The L integrators and the sampler each add one cycle of path delay, and the modulator loop is counted as one more. With the shift register in place, the end-to-end delay is a whole number of output samples, so a downstream consumer never sees a fractional-sample offset. Each input bit counts as +1 when high and −1 when low. The output word and a one-cycle valid strobe come out of a register.

Top module: `cic_decim`

## Requirements
- R1: The filter has L = MOD_ORDER + 1 integrator stages and L comb stages, and its response is a length-N boxcar convolved with itself L times (h, of length L·(N−1)+1).
- R2: The valid strobe is high for exactly one cycle, in the cycle after rising edge number m·N after reset release (m = 1, 2, ...), and is low in every other cycle.
- R3: A bit value 1 contributes +1 and a 0 contributes −1. Once the filter has settled, a constant run of ones gives the word +N^L and a constant run of zeros gives −N^L.
- R4: The word at strobe m equals the sum over k of h[k]·u(m·N − L − k). Here u(i) = 0 for i ≤ 0. For i ≥ 1, u(i) is the mapped bit that was sampled at rising edge i − D, with D = N − L − 2, and edges before reset release count as bit 0.
- R5: The output word holds its value in every cycle in which the valid strobe is low.
- R6: Internal registers and the output are L·log2(N)+2 bits wide and use two's-complement wrap-around. The output word is always within ±N^L.
- R7: A synchronous reset clears the integrators, the comb delay registers, the alignment shift register and the decimation counter. While reset is held, the valid strobe and the word are 0. After a reset in mid-stream, the output follows R2 and R4 counted from the new release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Modulator-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| bitIn | input | 1 | Modulator bitstream |
| wordOut | output | L·DECIM_LOG2+2 | Signed decimated word |
| wordValid | output | 1 | One-cycle strobe marking a new word |

## Verification
The bench builds two instances. One uses MOD_ORDER=1 and DECIM_LOG2=4 (L=2, N=16, D=12). The other uses MOD_ORDER=2 and DECIM_LOG2=3 (L=3, N=8, D=3). Together they exercise both filter orders and two alignment depths within a short run. With these small ratios the full convolution reference can be evaluated for every strobe. Full-scale runs of ones and zeros drive the output to its ±N^L extremes while the integrators wrap many times, and a mid-stream reset checks that alignment restarts from the new release.

// File: rtl/cic_pkg.sv
package cic_pkg;
  typedef struct packed {
    logic clear;   // synchronous clear for every datapath register
    logic sample;  // decimation instant: run combs, load output
  } cic_strobe_t;
endpackage

// File: rtl/cic_ctrl.sv
module cic_ctrl
  import cic_pkg::*;
#(
  parameter int DECIM_LOG2 = 10
) (
  input  logic        clk,
  input  logic        rst,
  output cic_strobe_t ctl
);
  logic [DECIM_LOG2-1:0] phaseCnt;

  always_ff @(posedge clk) begin
    if (rst) phaseCnt <= '0;
    else     phaseCnt <= phaseCnt + 1'b1;
  end

  always_comb begin
    ctl.clear  = rst;
    ctl.sample = (phaseCnt == {DECIM_LOG2{1'b1}});
  end

  // R2
  sample_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.sample |=> !ctl.sample);
endmodule

// File: rtl/cic_datapath.sv
module cic_datapath
  import cic_pkg::*;
#(
  parameter int STAGES     = 2,
  parameter int DECIM_LOG2 = 10,
  parameter int ALIGN      = 1020,
  parameter int WIDTH      = 22
) (
  input  logic                    clk,
  input  cic_strobe_t             ctl,
  input  logic                    bitIn,
  output logic signed [WIDTH-1:0] wordOut,
  output logic                    wordValid
);
  localparam logic signed [WIDTH-1:0] FULL_SCALE = WIDTH'(1) << (STAGES * DECIM_LOG2);

  // alignment shift register at the modulator rate
  logic [ALIGN-1:0] alignSr;
  generate
    if (ALIGN > 1) begin : g_srLong
      always_ff @(posedge clk) begin
        if (ctl.clear) alignSr <= '0;
        else           alignSr <= {alignSr[ALIGN-2:0], bitIn};
      end
    end else begin : g_srShort
      always_ff @(posedge clk) begin
        if (ctl.clear) alignSr <= '0;
        else           alignSr <= bitIn;
      end
    end
  endgenerate

  logic             tapBit;
  logic [WIDTH-1:0] stepVal;
  assign tapBit  = alignSr[ALIGN-1];
  assign stepVal = tapBit ? WIDTH'(1) : {WIDTH{1'b1}};

  // integrators, wrap-around accumulation
  logic [STAGES-1:0][WIDTH-1:0] integ;
  always_ff @(posedge clk) begin
    if (ctl.clear) begin
      integ <= '0;
    end else begin
      integ[0] <= integ[0] + stepVal;
      for (int i = 1; i < STAGES; i++) integ[i] <= integ[i] + integ[i-1];
    end
  end

  // comb chain at the decimated rate
  logic [STAGES:0][WIDTH-1:0]   combVal;
  logic [STAGES-1:0][WIDTH-1:0] combDly;
  always_comb begin
    combVal[0] = integ[STAGES-1];
    for (int i = 0; i < STAGES; i++) combVal[i+1] = combVal[i] - combDly[i];
  end

  always_ff @(posedge clk) begin
    if (ctl.clear) begin
      combDly   <= '0;
      wordOut   <= '0;
      wordValid <= 1'b0;
    end else begin
      wordValid <= ctl.sample;
      if (ctl.sample) begin
        for (int i = 0; i < STAGES; i++) combDly[i] <= combVal[i];
        wordOut <= $signed(combVal[STAGES]);
      end
    end
  end

  // R2
  valid_follows_sample_chk: assert property (@(posedge clk) disable iff (ctl.clear)
    ctl.sample |=> wordValid);
  // R5
  word_hold_chk: assert property (@(posedge clk) disable iff (ctl.clear)
    !ctl.sample |=> $stable(wordOut));
  // R6
  word_range_chk: assert property (@(posedge clk) disable iff (ctl.clear)
    wordValid |-> (wordOut <= FULL_SCALE && wordOut >= -FULL_SCALE));
endmodule

// File: rtl/cic_decim.sv
module cic_decim
  import cic_pkg::*;
#(
  parameter int MOD_ORDER  = 1,
  parameter int DECIM_LOG2 = 10
) (
  input  logic                                          clk,
  input  logic                                          rst,
  input  logic                                          bitIn,
  output logic signed [(MOD_ORDER+1)*DECIM_LOG2+1:0]    wordOut,
  output logic                                          wordValid
);
  localparam int STAGES = MOD_ORDER + 1;              // R1
  localparam int DECIM  = 1 << DECIM_LOG2;
  localparam int PATH   = STAGES + 2;
  localparam int ALIGN  = DECIM - PATH;
  localparam int WIDTH  = STAGES * DECIM_LOG2 + 2;    // R6

  cic_strobe_t ctl;

  cic_ctrl #(.DECIM_LOG2(DECIM_LOG2)) u_ctrl (
    .clk (clk),
    .rst (rst),
    .ctl (ctl)
  );

  cic_datapath #(
    .STAGES     (STAGES),
    .DECIM_LOG2 (DECIM_LOG2),
    .ALIGN      (ALIGN),
    .WIDTH      (WIDTH)
  ) u_dp (
    .clk       (clk),
    .ctl       (ctl),
    .bitIn     (bitIn),
    .wordOut   (wordOut),
    .wordValid (wordValid)
  );
endmodule

// File: tb/tb_cic_decim.sv
module tb_cic_decim;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bitIn = 1'b0;
  logic signed [9:0]  wordA;
  logic               validA;
  logic signed [10:0] wordB;
  logic               validB;

  always #2 clk = ~clk;

  cic_decim #(.MOD_ORDER(1), .DECIM_LOG2(4)) dut (
    .clk(clk), .rst(rst), .bitIn(bitIn), .wordOut(wordA), .wordValid(validA));
  cic_decim #(.MOD_ORDER(2), .DECIM_LOG2(3)) dut3 (
    .clk(clk), .rst(rst), .bitIn(bitIn), .wordOut(wordB), .wordValid(validB));

  int    nChecks = 0;
  int    nFails  = 0;
  int    edgeIdx = 0;
  bit    hist [0:8191];
  longint lastA, lastB;

  // R4 / R1: reference from the boxcar^L impulse response
  function automatic longint expWord(int m, int nDec, int ord);
    longint h [0:63];
    longint t [0:63];
    int len, dly, idx, j;
    longint acc;
    dly = nDec - ord - 2;
    for (int q = 0; q < 64; q++) h[q] = 0;
    h[0] = 1; len = 1;
    for (int s = 0; s < ord; s++) begin
      for (int q = 0; q < 64; q++) t[q] = 0;
      for (int q = 0; q < len + nDec - 1; q++)
        for (int r = 0; r < nDec; r++)
          if (q - r >= 0 && q - r < len) t[q] += h[q-r];
      len = len + nDec - 1;
      for (int q = 0; q < 64; q++) h[q] = t[q];
    end
    acc = 0;
    for (int k = 0; k < len; k++) begin
      idx = m * nDec - ord - k;
      if (idx >= 1) begin
        j = idx - dly;
        acc += h[k] * ((j >= 1 && hist[j]) ? 64'sd1 : -64'sd1);
      end
    end
    return acc;
  endfunction

  task automatic checkOne(string nm, int nDec, int ord, logic v, longint w, inout longint last);
    logic expV;
    expV = (edgeIdx % nDec) == 0;
    nChecks++;
    if (v !== expV) begin
      nFails++;
      $display("FAIL R2 %s edge %0d valid=%b expected %b", nm, edgeIdx, v, expV);
    end
    if (expV) begin
      longint e;
      e = expWord(edgeIdx / nDec, nDec, ord);
      nChecks++;
      if (w != e) begin
        nFails++;
        $display("FAIL R4 %s strobe %0d word=%0d expected %0d", nm, edgeIdx / nDec, w, e);
      end
      last = w;
    end else if (w != last) begin
      nChecks++; nFails++;
      $display("FAIL R5 %s edge %0d word=%0d expected held %0d", nm, edgeIdx, w, last);
    end
  endtask

  task automatic driveBit(bit b);
    edgeIdx++;
    hist[edgeIdx] = b;
    bitIn = b;
    @(negedge clk);
    checkOne("L2N16", 16, 2, validA, longint'(wordA), lastA);
    checkOne("L3N8", 8, 3, validB, longint'(wordB), lastB);
  endtask

  task automatic doReset();
    rst = 1'b1;
    bitIn = 1'b1;
    repeat (3) @(negedge clk);
    nChecks++;
    if (validA !== 1'b0 || wordA !== '0 || validB !== 1'b0 || wordB !== '0) begin
      nFails++;
      $display("FAIL R7 reset state vA=%b wA=%0d vB=%b wB=%0d expected 0 0 0 0",
               validA, wordA, validB, wordB);
    end
    rst = 1'b0;
    edgeIdx = 0;
    lastA = 0; lastB = 0;
    for (int i = 0; i < 8192; i++) hist[i] = 1'b0;
  endtask

  task automatic runRandom(int count, int pct);
    for (int i = 0; i < count; i++) driveBit(($urandom % 100) < pct);
  endtask

  task automatic checkFull(string what, longint a, longint b);
    nChecks++;
    if (lastA != a || lastB != b) begin
      nFails++;
      $display("FAIL R3 %s A=%0d B=%0d expected %0d %0d", what, lastA, lastB, a, b);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    doReset();
    runRandom(400, 50);
    repeat (200) driveBit(1'b1);
    checkFull("all ones", 256, 512);          // R3: +N^L
    repeat (200) driveBit(1'b0);
    checkFull("all zeros", -256, -512);       // R3: -N^L
    for (int i = 0; i < 240; i++) driveBit(i[0]);
    runRandom(300, 90);
    runRandom(300, 10);
    doReset();                                // R7: mid-stream reset
    repeat (100) driveBit(1'b1);
    checkFull("ones after reset", 256, 512);
    runRandom(1500, 65);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #400000;
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule